// File: doc/BRIEF.md
# Two-Way Set-Associative Translation Buffer

This block caches translations from a 20-bit effective page number to a 20-bit physical page number for 4 KB pages. It has 128 entries, arranged as 64 sets of two ways. A requester presents a full effective address. One cycle later the block answers with hit or miss and, on a hit, the physical address. The 12 offset bits are carried across unchanged.

On a miss the block goes busy and raises a refill request that carries the missing page number. An external table walker answers with exactly one entry. That entry holds the page number, the physical page number and the initial referenced and changed bits. The requester then retries the lookup. Software never writes entries.

The block keeps a referenced bit and a changed bit for each entry. Whenever a hit has to set either bit, the block updates its copy and pulses an update output so that the page table can be written back. The parameter `HAS_STORE` selects the variant: the data-side instance honours stores, and the instruction-side instance ties the store input off. Entries can be flushed all at once, or one page at a time.

Top module: `tlb2w`

## Requirements
- R1: After reset, `busy`, `refill_req`, `rsp_valid` and `upd_valid` are all low, and every entry is invalid.
- R2: A lookup is accepted when `lk_valid` is high and `busy` is low. In the next cycle `rsp_valid` is high. `rsp_hit` is high when a valid way in set `ea[17:12]` holds tag `ea[31:18]`. On a hit, `rsp_pa` = {stored physical page, `ea[11:0]`}.
- R3: A miss gives `rsp_hit`=0. From the next cycle, `refill_req` and `busy` stay high, and `refill_vpn` holds `ea[31:12]` of the missed lookup. A lookup presented while `busy` is high gets no response.
- R4: A cycle with `refill_valid` high while `refill_req` is high writes the entry. `refill_req` and `busy` are low in the following cycle, and the written page hits from then on.
- R5: A refill writes an invalid way of its set first, and way 0 before way 1. A valid way in the same set is left intact.
- R6: When both ways of the set are valid, a refill replaces the least recently used way. Every hit and every refill marks its way as the most recently used.
- R7: A hit on an entry whose referenced bit is clear pulses `upd_valid` in the response cycle. The pulse carries `upd_vpn` equal to the page and `upd_chg` equal to the new changed bit. The entry's referenced bit becomes set, so the next hit on it gives no pulse.
- R8: A store hit on an entry whose changed bit is clear pulses `upd_valid` with `upd_chg`=1 and sets the bit. A later store hit on that entry gives no pulse.
- R9: The referenced and changed bits supplied with a refill are stored as given. An entry refilled with both bits set gives no update pulse, even on a store hit.
- R10: `inv_one` clears only the way whose tag matches `inv_vpn` in set `inv_vpn[5:0]`. The other way of that set still hits.
- R11: `inv_all` clears every entry in one cycle, so any following lookup misses.
- R12: Entries with the same tag but different set indices are independent: one can miss while the other hits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_ea | input | 32 | Effective address of the lookup |
| lk_store | input | 1 | Lookup is a store (ignored when HAS_STORE=0) |
| busy | output | 1 | Lookups are not accepted this cycle |
| rsp_valid | output | 1 | Lookup response valid |
| rsp_hit | output | 1 | Response is a hit |
| rsp_pa | output | 32 | Physical address on a hit |
| refill_req | output | 1 | Refill pending |
| refill_vpn | output | 20 | Page number to be refilled |
| refill_valid | input | 1 | Refill entry present |
| refill_page | input | 20 | Effective page number of the refill entry |
| refill_ppn | input | 20 | Physical page number of the refill entry |
| refill_ref | input | 1 | Initial referenced bit |
| refill_chg | input | 1 | Initial changed bit |
| upd_valid | output | 1 | Status bits must be written back |
| upd_vpn | output | 20 | Page whose status bits changed |
| upd_chg | output | 1 | New changed bit (the referenced bit is always set) |
| inv_all | input | 1 | Flush all entries |
| inv_one | input | 1 | Flush the entry for one page |
| inv_vpn | input | 20 | Page to flush |

## Verification
The bench fills one set through a chain of misses. It steers the replacement order so that a design that picks the wrong victim, or fails to refresh recency on hits, evicts a page that is still hit afterwards. The status-bit cases pair every update pulse with a second access that must stay silent: a design that reports without storing the bit pulses twice, and one that ignores store accesses never reports the changed bit. A single-page flush followed by a refill into the freed way catches designs that clear both ways or overwrite the surviving one. Pages that share a tag across sets catch index bits left out of the match.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int EA_W  = 32;
  localparam int OFF_W = 12;
  localparam int SET_W = 6;
  localparam int PPN_W = 20;
  localparam int NWAYS = 2;

  typedef enum logic {
    WAY_LO = 1'b0,
    WAY_HI = 1'b1
  } way_e;
endpackage

// File: rtl/tlb_way_array.sv
module tlb_way_array #(
  parameter  int SET_W = 6,
  parameter  int TAG_W = 14,
  parameter  int PPN_W = 20,
  localparam int SETS  = 1 << SET_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] rd_idx,
  output logic             rd_vld,
  output logic [TAG_W-1:0] rd_tag,
  output logic [PPN_W-1:0] rd_ppn,
  output logic             rd_ref,
  output logic             rd_chg,
  output logic [SETS-1:0]  vld_vec,
  input  logic             wr_en,
  input  logic [SET_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [PPN_W-1:0] wr_ppn,
  input  logic             wr_ref,
  input  logic             wr_chg,
  input  logic             st_en,
  input  logic [SET_W-1:0] st_idx,
  input  logic             st_chg,
  input  logic             inv_one,
  input  logic [SET_W-1:0] inv_idx,
  input  logic [TAG_W-1:0] inv_tag,
  input  logic             inv_all
);
  logic [SETS-1:0]  vld_q, vld_d;
  logic [SETS-1:0]  ref_q, ref_d;
  logic [SETS-1:0]  chg_q, chg_d;
  logic [TAG_W-1:0] tag_q [SETS];
  logic [PPN_W-1:0] ppn_q [SETS];

  assign rd_vld  = vld_q[rd_idx];
  assign rd_tag  = tag_q[rd_idx];
  assign rd_ppn  = ppn_q[rd_idx];
  assign rd_ref  = ref_q[rd_idx];
  assign rd_chg  = chg_q[rd_idx];
  assign vld_vec = vld_q;

  always_comb begin
    vld_d = vld_q;
    ref_d = ref_q;
    chg_d = chg_q;
    if (st_en) begin
      ref_d[st_idx] = 1'b1;
      chg_d[st_idx] = chg_q[st_idx] | st_chg;
    end
    if (wr_en) begin
      vld_d[wr_idx] = 1'b1;
      ref_d[wr_idx] = wr_ref;
      chg_d[wr_idx] = wr_chg;
    end
    if (inv_one && (tag_q[inv_idx] == inv_tag)) begin
      vld_d[inv_idx] = 1'b0;
    end
    if (inv_all) begin
      vld_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      ref_q <= '0;
      chg_q <= '0;
    end else begin
      vld_q <= vld_d;
      ref_q <= ref_d;
      chg_q <= chg_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx] <= wr_tag;
      ppn_q[wr_idx] <= wr_ppn;
    end
  end

  // R11: a flush leaves no valid entry behind
  p_flush_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> (vld_q == '0));

  // R4: a written entry is valid afterwards unless flushed
  p_write_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !inv_all && !inv_one) |=> vld_q[$past(wr_idx)]);
endmodule

// File: rtl/tlb_lru.sv
module tlb_lru #(
  parameter  int SET_W = 6,
  localparam int SETS  = 1 << SET_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] rd_idx,
  output tlb_pkg::way_e    victim,
  input  logic             upd_en,
  input  logic [SET_W-1:0] upd_idx,
  input  tlb_pkg::way_e    upd_way
);
  logic [SETS-1:0] old_q, old_d;

  assign victim = tlb_pkg::way_e'(old_q[rd_idx]);

  always_comb begin
    old_d = old_q;
    if (upd_en) begin
      old_d[upd_idx] = ~upd_way;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      old_q <= '0;
    end else begin
      old_q <= old_d;
    end
  end

  logic             chk_en_q;
  logic [SET_W-1:0] chk_idx_q;
  logic             chk_way_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_en_q  <= 1'b0;
      chk_idx_q <= '0;
      chk_way_q <= 1'b0;
    end else begin
      chk_en_q  <= upd_en;
      chk_idx_q <= upd_idx;
      chk_way_q <= upd_way;
    end
  end

  // R6: a used way is never the next victim of its set
  p_recency_r6: assert property (@(posedge clk) disable iff (!rst_n)
    chk_en_q |-> (old_q[chk_idx_q] != chk_way_q));
endmodule

// File: rtl/tlb2w.sv
module tlb2w #(
  parameter  int EA_W      = tlb_pkg::EA_W,
  parameter  int OFF_W     = tlb_pkg::OFF_W,
  parameter  int SET_W     = tlb_pkg::SET_W,
  parameter  int PPN_W     = tlb_pkg::PPN_W,
  parameter  bit HAS_STORE = 1'b1,
  localparam int VPN_W     = EA_W - OFF_W,
  localparam int TAG_W     = VPN_W - SET_W,
  localparam int SETS      = 1 << SET_W,
  localparam int NWAYS     = tlb_pkg::NWAYS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [EA_W-1:0]  lk_ea,
  input  logic             lk_store,
  output logic             busy,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic [PPN_W+OFF_W-1:0] rsp_pa,
  output logic             refill_req,
  output logic [VPN_W-1:0] refill_vpn,
  input  logic             refill_valid,
  input  logic [VPN_W-1:0] refill_page,
  input  logic [PPN_W-1:0] refill_ppn,
  input  logic             refill_ref,
  input  logic             refill_chg,
  output logic             upd_valid,
  output logic [VPN_W-1:0] upd_vpn,
  output logic             upd_chg,
  input  logic             inv_all,
  input  logic             inv_one,
  input  logic [VPN_W-1:0] inv_vpn
);
  import tlb_pkg::*;

  // lookup address split
  logic [VPN_W-1:0] lk_vpn;
  logic [SET_W-1:0] lk_idx;
  logic [TAG_W-1:0] lk_tag;
  logic [OFF_W-1:0] lk_off;
  assign lk_vpn = lk_ea[EA_W-1:OFF_W];
  assign lk_off = lk_ea[OFF_W-1:0];
  assign lk_idx = lk_vpn[SET_W-1:0];
  assign lk_tag = lk_vpn[VPN_W-1:SET_W];

  logic [SET_W-1:0] rf_idx;
  logic [TAG_W-1:0] rf_tag;
  assign rf_idx = refill_page[SET_W-1:0];
  assign rf_tag = refill_page[VPN_W-1:SET_W];

  // store qualification per variant
  logic store_eff;
  generate
    if (HAS_STORE) begin : g_data_side
      assign store_eff = lk_store;
    end else begin : g_instr_side
      assign store_eff = 1'b0;
    end
  endgenerate

  // control state
  logic             pend_q, pend_d;
  logic [VPN_W-1:0] miss_vpn_q, miss_vpn_d;
  logic             rsp_valid_q, rsp_hit_q, upd_valid_q;
  logic             rsp_valid_d, rsp_hit_d, upd_valid_d;
  logic [PPN_W+OFF_W-1:0] rsp_pa_q, rsp_pa_d;
  logic [VPN_W-1:0] upd_vpn_q;
  logic             upd_chg_q, upd_chg_d;

  logic acc, refill_fire;
  assign busy        = pend_q | inv_all | inv_one;
  assign acc         = lk_valid & ~busy;
  assign refill_fire = refill_valid & pend_q;

  // way storage
  logic [NWAYS-1:0] rd_vld, rd_ref, rd_chg, hit_vec, wr_en_w, st_en_w;
  logic [TAG_W-1:0] rd_tag [NWAYS];
  logic [PPN_W-1:0] rd_ppn [NWAYS];
  logic [SETS-1:0]  vld_vec [NWAYS];
  logic             needs_upd;
  way_e             hit_way, victim_way, lru_way, lru_upd_way;

  generate
    for (genvar w = 0; w < NWAYS; w++) begin : g_way
      assign hit_vec[w] = rd_vld[w] && (rd_tag[w] == lk_tag);
      assign wr_en_w[w] = refill_fire && (victim_way == way_e'(w));
      assign st_en_w[w] = needs_upd && (hit_way == way_e'(w));

      tlb_way_array #(
        .SET_W (SET_W),
        .TAG_W (TAG_W),
        .PPN_W (PPN_W)
      ) i_way (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (lk_idx),
        .rd_vld  (rd_vld[w]),
        .rd_tag  (rd_tag[w]),
        .rd_ppn  (rd_ppn[w]),
        .rd_ref  (rd_ref[w]),
        .rd_chg  (rd_chg[w]),
        .vld_vec (vld_vec[w]),
        .wr_en   (wr_en_w[w]),
        .wr_idx  (rf_idx),
        .wr_tag  (rf_tag),
        .wr_ppn  (refill_ppn),
        .wr_ref  (refill_ref),
        .wr_chg  (refill_chg),
        .st_en   (st_en_w[w]),
        .st_idx  (lk_idx),
        .st_chg  (store_eff),
        .inv_one (inv_one),
        .inv_idx (inv_vpn[SET_W-1:0]),
        .inv_tag (inv_vpn[VPN_W-1:SET_W]),
        .inv_all (inv_all)
      );
    end
  endgenerate

  // hit selection
  logic             hit, ref_sel, chg_sel;
  logic [PPN_W-1:0] ppn_sel;
  assign hit     = |hit_vec;
  assign hit_way = hit_vec[1] ? WAY_HI : WAY_LO;
  assign ppn_sel = rd_ppn[hit_way];
  assign ref_sel = rd_ref[hit_way];
  assign chg_sel = rd_chg[hit_way];
  assign needs_upd = acc && hit && (!ref_sel || (store_eff && !chg_sel));

  // victim selection: invalid way first, then least recently used
  always_comb begin
    if (!vld_vec[0][rf_idx]) begin
      victim_way = WAY_LO;
    end else if (!vld_vec[1][rf_idx]) begin
      victim_way = WAY_HI;
    end else begin
      victim_way = lru_way;
    end
  end

  assign lru_upd_way = refill_fire ? victim_way : hit_way;

  tlb_lru #(.SET_W(SET_W)) i_lru (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_idx  (rf_idx),
    .victim  (lru_way),
    .upd_en  (refill_fire | (acc & hit)),
    .upd_idx (refill_fire ? rf_idx : lk_idx),
    .upd_way (lru_upd_way)
  );

  // next state
  always_comb begin
    pend_d      = pend_q;
    miss_vpn_d  = miss_vpn_q;
    rsp_valid_d = acc;
    rsp_hit_d   = acc & hit;
    rsp_pa_d    = {ppn_sel, lk_off};
    upd_valid_d = needs_upd;
    upd_chg_d   = chg_sel | store_eff;
    if (acc && !hit) begin
      pend_d     = 1'b1;
      miss_vpn_d = lk_vpn;
    end
    if (refill_fire) begin
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q      <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
      upd_valid_q <= 1'b0;
    end else begin
      pend_q      <= pend_d;
      rsp_valid_q <= rsp_valid_d;
      rsp_hit_q   <= rsp_hit_d;
      upd_valid_q <= upd_valid_d;
    end
  end

  always_ff @(posedge clk) begin
    if (acc) begin
      rsp_pa_q   <= rsp_pa_d;
      upd_vpn_q  <= lk_vpn;
      upd_chg_q  <= upd_chg_d;
      miss_vpn_q <= miss_vpn_d;
    end
  end

  assign rsp_valid  = rsp_valid_q;
  assign rsp_hit    = rsp_hit_q;
  assign rsp_pa     = rsp_pa_q;
  assign refill_req = pend_q;
  assign refill_vpn = miss_vpn_q;
  assign upd_valid  = upd_valid_q;
  assign upd_vpn    = upd_vpn_q;
  assign upd_chg    = upd_chg_q;

  // R3: a missed response always comes with a pending refill
  p_miss_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (refill_req && busy));

  // R3: no response to a lookup offered while a refill is pending
  p_busy_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (refill_req && lk_valid) |=> !rsp_valid);

  // R4: the refill closes the pending request
  p_refill_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (refill_valid && refill_req) |=> !refill_req);

  // R2: at most one way matches an accepted lookup
  p_one_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !busy) |-> $onehot0(hit_vec));

  // R7: a write-back pulse only accompanies a hit
  p_upd_on_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> (rsp_valid && rsp_hit));
endmodule

// File: tb/test_tlb2w.sv
`timescale 1ns/1ps
module test_tlb2w;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_ea = '0;
  logic        lk_store = 1'b0;
  logic        busy, rsp_valid, rsp_hit, refill_req, upd_valid, upd_chg;
  logic [31:0] rsp_pa;
  logic [19:0] refill_vpn, upd_vpn;
  logic        refill_valid = 1'b0;
  logic [19:0] refill_page = '0, refill_ppn = '0;
  logic        refill_ref = 1'b0, refill_chg = 1'b0;
  logic        inv_all = 1'b0, inv_one = 1'b0;
  logic [19:0] inv_vpn = '0;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  tlb2w i_tlb2w (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_ea(lk_ea),
    .lk_store(lk_store), .busy(busy), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .rsp_pa(rsp_pa), .refill_req(refill_req),
    .refill_vpn(refill_vpn), .refill_valid(refill_valid),
    .refill_page(refill_page), .refill_ppn(refill_ppn),
    .refill_ref(refill_ref), .refill_chg(refill_chg),
    .upd_valid(upd_valid), .upd_vpn(upd_vpn), .upd_chg(upd_chg),
    .inv_all(inv_all), .inv_one(inv_one), .inv_vpn(inv_vpn)
  );

  typedef struct {
    bit          hit;
    logic [31:0] pa;
    bit          upd;
    logic [19:0] uvpn;
    bit          uchg;
    string       tag;
  } exp_t;

  exp_t sb[$];

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic logic [19:0] pg(input logic [13:0] t, input logic [5:0] i);
    return {t, i};
  endfunction

  // monitor: pops one expectation per response
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (sb.size() == 0) begin
        check(1'b0, "R3 unexpected response", 64'(rsp_valid), 64'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(rsp_hit == e.hit, {e.tag, " hit"}, 64'(rsp_hit), 64'(e.hit));
        if (e.hit) check(rsp_pa == e.pa, {e.tag, " pa"}, 64'(rsp_pa), 64'(e.pa));
        check(upd_valid == e.upd, {e.tag, " upd_valid"}, 64'(upd_valid), 64'(e.upd));
        if (e.upd && upd_valid) begin
          check(upd_vpn == e.uvpn, {e.tag, " upd_vpn"}, 64'(upd_vpn), 64'(e.uvpn));
          check(upd_chg == e.uchg, {e.tag, " upd_chg"}, 64'(upd_chg), 64'(e.uchg));
        end
      end
    end else if (rst_n && upd_valid) begin
      check(1'b0, "R7 pulse without response", 64'(upd_valid), 64'd0);
    end
  end

  // driver: one lookup, expectation pushed first
  task automatic lookup(input logic [19:0] vpn, input logic [11:0] off,
                        input bit st, input bit eh, input logic [19:0] ppn,
                        input bit eu, input bit euc, input string tag);
    exp_t e;
    while (busy) @(negedge clk);
    e.hit = eh; e.pa = {ppn, off}; e.upd = eu; e.uvpn = vpn; e.uchg = euc; e.tag = tag;
    sb.push_back(e);
    lk_valid = 1'b1; lk_ea = {vpn, off}; lk_store = st;
    @(negedge clk);
    lk_valid = 1'b0; lk_store = 1'b0;
  endtask

  task automatic refill(input logic [19:0] vpn, input logic [19:0] ppn,
                        input bit r, input bit c, input string tag);
    check(refill_req && busy, {tag, " R3 refill_req/busy"}, 64'({refill_req, busy}), 64'd3);
    check(refill_vpn == vpn, {tag, " R3 refill_vpn"}, 64'(refill_vpn), 64'(vpn));
    refill_valid = 1'b1; refill_page = vpn; refill_ppn = ppn;
    refill_ref = r; refill_chg = c;
    @(negedge clk);
    refill_valid = 1'b0;
    check(!refill_req && !busy, {tag, " R4 released"}, 64'({refill_req, busy}), 64'd0);
  endtask

  task automatic miss_fill(input logic [19:0] vpn, input logic [19:0] ppn,
                           input bit r, input bit c, input string tag);
    lookup(vpn, 12'h0, 1'b0, 1'b0, '0, 1'b0, 1'b0, tag);
    refill(vpn, ppn, r, c, tag);
  endtask

  logic [19:0] pa_a, pa_b, pa_c, pa_d;

  initial begin
    pa_a = pg(14'h011, 6'd5);
    pa_b = pg(14'h022, 6'd5);
    pa_c = pg(14'h033, 6'd5);
    pa_d = pg(14'h011, 6'd9);
    repeat (3) @(negedge clk);
    check(!busy && !refill_req && !rsp_valid && !upd_valid, "R1 reset outputs",
          64'({busy, refill_req, rsp_valid, upd_valid}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // first miss, then an ignored lookup while busy
    lookup(pa_a, 12'h0, 1'b0, 1'b0, '0, 1'b0, 1'b0, "R3 first miss");
    check(busy, "R3 busy after miss", 64'(busy), 64'd1);
    lk_valid = 1'b1; lk_ea = {pa_b, 12'h0};
    @(negedge clk);
    lk_valid = 1'b0;
    check(!rsp_valid, "R3 lookup during busy ignored", 64'(rsp_valid), 64'd0);
    refill(pa_a, 20'hAAAA1, 1'b0, 1'b0, "R4 refill A");

    // status bits
    lookup(pa_a, 12'h123, 1'b0, 1'b1, 20'hAAAA1, 1'b1, 1'b0, "R2 R7 hit sets ref");
    lookup(pa_a, 12'hFFF, 1'b0, 1'b1, 20'hAAAA1, 1'b0, 1'b0, "R7 second hit quiet");
    lookup(pa_a, 12'h004, 1'b1, 1'b1, 20'hAAAA1, 1'b1, 1'b1, "R8 store sets chg");
    lookup(pa_a, 12'h008, 1'b1, 1'b1, 20'hAAAA1, 1'b0, 1'b0, "R8 second store quiet");

    // fill second way, then replacement order in set 5
    miss_fill(pa_b, 20'hBBBB2, 1'b1, 1'b0, "R5 B to free way");
    lookup(pa_b, 12'h010, 1'b0, 1'b1, 20'hBBBB2, 1'b0, 1'b0, "R9 B ref given");
    lookup(pa_a, 12'h020, 1'b0, 1'b1, 20'hAAAA1, 1'b0, 1'b0, "R5 A kept");
    miss_fill(pa_c, 20'hCCCC3, 1'b1, 1'b1, "R6 C evicts B");
    lookup(pa_a, 12'h030, 1'b0, 1'b1, 20'hAAAA1, 1'b0, 1'b0, "R6 A survives");
    miss_fill(pa_b, 20'hBBBB4, 1'b1, 1'b0, "R6 B was evicted");
    miss_fill(pa_c, 20'hCCCC5, 1'b1, 1'b1, "R6 C was evicted");
    lookup(pa_c, 12'h040, 1'b1, 1'b1, 20'hCCCC5, 1'b0, 1'b0, "R9 store on ref+chg quiet");
    miss_fill(pa_a, 20'hAAAA6, 1'b0, 1'b0, "R6 A was evicted");
    lookup(pa_c, 12'h050, 1'b0, 1'b1, 20'hCCCC5, 1'b0, 1'b0, "R6 C survives");

    // same tag, other set
    miss_fill(pa_d, 20'hDDDD7, 1'b1, 1'b1, "R12 D misses");
    lookup(pa_d, 12'h060, 1'b0, 1'b1, 20'hDDDD7, 1'b0, 1'b0, "R12 D hits");
    lookup(pa_a, 12'h070, 1'b0, 1'b1, 20'hAAAA6, 1'b1, 1'b0, "R12 R7 A separate");

    // single-page flush
    inv_one = 1'b1; inv_vpn = pa_c;
    @(negedge clk);
    inv_one = 1'b0;
    lookup(pa_a, 12'h080, 1'b0, 1'b1, 20'hAAAA6, 1'b0, 1'b0, "R10 other way kept");
    miss_fill(pa_c, 20'hCCCC8, 1'b1, 1'b1, "R10 C flushed");
    lookup(pa_a, 12'h090, 1'b0, 1'b1, 20'hAAAA6, 1'b0, 1'b0, "R5 refill used freed way");
    lookup(pa_c, 12'h0A0, 1'b0, 1'b1, 20'hCCCC8, 1'b0, 1'b0, "R5 C refilled");

    // full flush
    inv_all = 1'b1;
    @(negedge clk);
    inv_all = 1'b0;
    miss_fill(pa_d, 20'hDDDD9, 1'b1, 1'b1, "R11 D flushed");
    miss_fill(pa_a, 20'hAAAAB, 1'b1, 1'b1, "R11 A flushed");
    lookup(pa_a, 12'h0B0, 1'b0, 1'b1, 20'hAAAAB, 1'b0, 1'b0, "R4 A hits after refill");

    repeat (4) @(negedge clk);
    check(sb.size() == 0, "R2 all responses seen", 64'(sb.size()), 64'd0);
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule